// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block emits one fixed-width clamp pulse per horizontal line. It times the pulse from a horizontal-drive signal that an earlier stage has already cleaned up and made active-high. The pulse can sit in either of two places. In the first, it is timed from the leading (rising) edge of horizontal drive and lies inside the sync pulse. In the second, it is timed from the trailing (falling) edge and lies in the back porch. A two-bit select forces one of the two positions or hands the choice to an automatic rule. The rule looks at two source-presence flags: one for composite/horizontal sync and one for sync carried on video.

Delay and width are both counts of clock cycles, so the pulse can be tuned. The defaults are a delay of 2 and a width of 30. At a 100 MHz clock that gives a pulse of about 300 ns. The same pulse appears on an active-high output and on its complement.

During the vertical-drive interval the pulse is held off, except when separate horizontal and vertical sync inputs are in use. A new trigger edge always restarts the timing, so a pulse never spans two lines.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `pos_sel_i` = 2'b00 (back porch), the first clock edge that samples `hdrive_i` low after a high sample is the trigger edge. `clamp_p_o` is high from trigger edge + `delay_i` + 1 onward.
- R2: With `pos_sel_i` = 2'b01 (sync interval), the first clock edge that samples `hdrive_i` high after a low sample is the trigger edge. The same delay rule as R1 applies.
- R3: With `pos_sel_i[1]` = 1 (automatic), the sync-interval position is used when `comp_seen_i` = 1 and `video_seen_i` = 0. Every other flag combination uses the back-porch position.
- R4: An uninterrupted pulse stays high for exactly `width_i` cycles. With `width_i` = 0 no pulse is produced.
- R5: In the sync-interval position, the clock edge that samples `hdrive_i` falling ends any pending or running pulse. `clamp_p_o` is low after that edge.
- R6: A trigger edge that arrives while a pulse is pending or running cancels it: the output is low after that edge, and a fresh delay count starts.
- R7: While `vdrive_i` = 1 and `sep_sync_i` = 0, `clamp_p_o` is held low. When `sep_sync_i` = 1, `vdrive_i` has no effect.
- R8: `clamp_n_o` is always the complement of `clamp_p_o`.
- R9: While `rst_n` is low at a clock edge, the timer goes idle: `clamp_p_o` = 0 and `clamp_n_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdrive_i | input | 1 | Horizontal drive, active high |
| vdrive_i | input | 1 | Vertical drive interval flag |
| sep_sync_i | input | 1 | Separate horizontal and vertical sync in use |
| comp_seen_i | input | 1 | Composite/horizontal sync present |
| video_seen_i | input | 1 | Sync on video present |
| pos_sel_i | input | 2 | 00 back porch, 01 sync interval, 1x automatic |
| width_i | input | CNT_W | Pulse width in clocks |
| delay_i | input | CNT_W | Delay from trigger edge in clocks |
| clamp_p_o | output | 1 | Clamp pulse, active high |
| clamp_n_o | output | 1 | Clamp pulse, active low |

## Verification
Suppose the line timer holds a wrong count or state. The clamp edges then land in the wrong cycle within the same line: one cycle early or late, or with a pulse that never ends. A bench that compares every cycle catches this within `delay_i` + `width_i` + 1 cycles of the trigger edge. A wrong choice of position shows up as a pulse that follows the wrong edge of horizontal drive, one line after the select changes. A blanking fault shows up as a pulse during vertical drive, or a missing pulse there, on the first line inside that interval.

// File: rtl/clamp_pkg.sv
// Shared types for the line clamp pulse generator.
package clamp_pkg;
    // Line timer states
    typedef enum logic [1:0] {
        CT_IDLE   = 2'b00,
        CT_WAIT   = 2'b01,
        CT_ACTIVE = 2'b10
    } ctimer_e;

    // Select encodings (bit 1 set means automatic)
    localparam logic [1:0] POS_BACK = 2'b00;
    localparam logic [1:0] POS_SYNC = 2'b01;
endpackage

// File: rtl/clamp_hedge.sv
// Edge finder for horizontal drive.
// Assumes hd_i is already synchronous to clk; one register of history.
module clamp_hedge (
    input  logic clk,
    input  logic rst_n,
    input  logic hd_i,
    output logic rise_o,
    output logic fall_o
);
    logic hd_q;

    // Keep the previous sample of horizontal drive
    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= 1'b0;
        else        hd_q <= hd_i;
    end

    // Compare the current sample with the stored one
    always_comb begin
        rise_o = hd_i & ~hd_q;
        fall_o = ~hd_i & hd_q;
    end
endmodule

// File: rtl/clamp_place.sv
// Position resolver and vertical blanking qualifier.
// Chooses which horizontal edge starts the pulse, whether a falling
// edge truncates it, and whether output is blanked this cycle.
// Assumes all inputs are synchronous and stable around the clock edge.
module clamp_place
    import clamp_pkg::*;
(
    input  logic [1:0] pos_sel_i,
    input  logic       comp_seen_i,
    input  logic       video_seen_i,
    input  logic       vdrive_i,
    input  logic       sep_sync_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       trig_o,
    output logic       cut_o,
    output logic       blank_o
);
    logic in_sync;

    // Resolve forced or automatic position
    always_comb begin
        if (pos_sel_i[1])            in_sync = comp_seen_i & ~video_seen_i;
        else if (pos_sel_i == POS_SYNC) in_sync = 1'b1;
        else                         in_sync = 1'b0;
    end

    // Pick trigger edge, truncation and blanking
    always_comb begin
        trig_o  = in_sync ? rise_i : fall_i;
        cut_o   = in_sync & fall_i;
        blank_o = vdrive_i & ~sep_sync_i;
    end
endmodule

// File: rtl/clamp_timer.sv
// Per-line delay and width timer.
// A trigger always restarts the delay; cut abandons the line.
// delay_i is taken at the trigger, width_i when the delay ends.
module clamp_timer
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             cut_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ctimer_e          state;
    logic [CNT_W-1:0] cnt;

    // Sequence through delay and width for one line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CT_IDLE;
            cnt   <= '0;
        end else if (trig_i) begin
            state <= CT_WAIT;
            cnt   <= delay_i;
        end else if (cut_i) begin
            state <= CT_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                CT_WAIT: begin
                    if (cnt == '0) begin
                        if (width_i == '0) begin
                            state <= CT_IDLE;
                        end else begin
                            state <= CT_ACTIVE;
                            cnt   <= width_i - ONE;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                CT_ACTIVE: begin
                    if (cnt == '0) state <= CT_IDLE;
                    else           cnt   <= cnt - ONE;
                end
                default: begin
                    state <= CT_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Pulse is the active state
    always_comb active_o = (state == CT_ACTIVE);
endmodule

// File: rtl/clamp_pulse_gen.sv
// Line clamp pulse generator top.
// Emits a delayed fixed-width pulse per line in the sync or back porch
// position, with blanking during vertical drive for non-separate sync.
// Assumes hdrive_i is cleaned, active high and synchronous to clk.
module clamp_pulse_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdrive_i,
    input  logic             vdrive_i,
    input  logic             sep_sync_i,
    input  logic             comp_seen_i,
    input  logic             video_seen_i,
    input  logic [1:0]       pos_sel_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             clamp_p_o,
    output logic             clamp_n_o
);
    logic rise, fall, trig, cut, blank, active;

    clamp_hedge u_hedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .hd_i   (hdrive_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    clamp_place u_place (
        .pos_sel_i    (pos_sel_i),
        .comp_seen_i  (comp_seen_i),
        .video_seen_i (video_seen_i),
        .vdrive_i     (vdrive_i),
        .sep_sync_i   (sep_sync_i),
        .rise_i       (rise),
        .fall_i       (fall),
        .trig_o       (trig),
        .cut_o        (cut),
        .blank_o      (blank)
    );

    clamp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .cut_i    (cut),
        .delay_i  (delay_i),
        .width_i  (width_i),
        .active_o (active)
    );

    // Gate the pulse and drive both polarities
    always_comb begin
        clamp_p_o = active & ~blank;
        clamp_n_o = ~clamp_p_o;
    end
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
// Assertion checker for clamp_pulse_gen, attached by bind.
// Observes ports only; keeps one run-length counter of its own.
module clamp_pulse_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdrive_i,
    input logic             vdrive_i,
    input logic             sep_sync_i,
    input logic             comp_seen_i,
    input logic             video_seen_i,
    input logic [1:0]       pos_sel_i,
    input logic [CNT_W-1:0] width_i,
    input logic             clamp_p_o,
    input logic             clamp_n_o
);
    logic [CNT_W:0] run;

    // Count consecutive high cycles of the clamp pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= '0;
        else if (clamp_p_o) run <= run + 1'b1;
        else                run <= '0;
    end

    p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_n_o == !clamp_p_o);

    p_vblank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vdrive_i && !sep_sync_i) |-> !clamp_p_o);

    p_width_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_p_o |-> (run < {1'b0, width_i}));

    p_bp_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pos_sel_i == 2'b00 && !hdrive_i && $past(hdrive_i))
        |=> !clamp_p_o);

    p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pos_sel_i == 2'b01 && hdrive_i && !$past(hdrive_i))
        |=> !clamp_p_o);

    p_sync_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pos_sel_i == 2'b01 && !hdrive_i && $past(hdrive_i))
        |=> !clamp_p_o);

    p_auto_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pos_sel_i[1] && comp_seen_i && !video_seen_i
         && !hdrive_i && $past(hdrive_i)) |=> !clamp_p_o);
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdrive_i     (hdrive_i),
    .vdrive_i     (vdrive_i),
    .sep_sync_i   (sep_sync_i),
    .comp_seen_i  (comp_seen_i),
    .video_seen_i (video_seen_i),
    .pos_sel_i    (pos_sel_i),
    .width_i      (width_i),
    .clamp_p_o    (clamp_p_o),
    .clamp_n_o    (clamp_n_o)
);

// File: tb/clamp_pulse_gen_test.sv
// Bench for clamp_pulse_gen: directed corners plus seeded random lines,
// compared every cycle against a line model built from the requirements.
module clamp_pulse_gen_test;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, hd, vd, sep, comp, video;
    logic [1:0]    sel;
    logic [CW-1:0] wid, dly;
    logic          cp, cn;

    clamp_pulse_gen #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hdrive_i(hd), .vdrive_i(vd),
        .sep_sync_i(sep), .comp_seen_i(comp), .video_seen_i(video),
        .pos_sel_i(sel), .width_i(wid), .delay_i(dly),
        .clamp_p_o(cp), .clamp_n_o(cn)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R9";

    // Line model: cycles since trigger and whether the line is still live
    bit m_hd = 0;
    bit live = 0;
    int n = 0;

    function automatic bit sync_pos();
        if (sel[1]) return comp && !video;
        return sel == 2'b01;
    endfunction

    function automatic bit expect_p();
        int d = int'(dly);
        int w = int'(wid);
        if (vd && !sep) return 1'b0;
        return live && n >= d + 1 && n <= d + w;
    endfunction

    task automatic model_edge();
        bit rise, fall, trig;
        if (!rst_n) begin
            live = 0; n = 0; m_hd = 0;
            return;
        end
        rise = hd && !m_hd;
        fall = !hd && m_hd;
        trig = sync_pos() ? rise : fall;
        if (trig) begin
            n = 0; live = 1;
        end else if (live) begin
            if (sync_pos() && fall) live = 0;
            else n++;
            if (n > int'(dly) + int'(wid)) live = 0;
        end
        m_hd = hd;
    endtask

    task automatic check_out();
        bit e = expect_p();
        total++;
        if (cp !== e) begin
            bad++;
            $display("FAIL %s clamp_p actual=%0b expected=%0b at %0t", tag, cp, e, $time);
        end
        total++;
        if (cn !== ~e) begin
            bad++;
            $display("FAIL R8 clamp_n actual=%0b expected=%0b at %0t", cn, ~e, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out();
    endtask

    task automatic line(int hi, int lo);
        hd = 1'b1;
        for (int i = 0; i < hi; i++) step();
        hd = 1'b0;
        for (int i = 0; i < lo; i++) step();
    endtask

    task automatic idle(int c);
        hd = 1'b0;
        for (int i = 0; i < c; i++) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_c1a9));
        rst_n = 0; hd = 0; vd = 0; sep = 0; comp = 0; video = 0;
        sel = 2'b00; wid = 8'd30; dly = 8'd2;
        // R9: reset state
        tag = "R9";
        for (int i = 0; i < 4; i++) step();
        rst_n = 1;

        // R1: back porch at default timing
        tag = "R1"; sel = 2'b00;
        for (int i = 0; i < 3; i++) line(12, 60);

        // R2: sync interval, long sync gives full width
        tag = "R2"; sel = 2'b01;
        for (int i = 0; i < 3; i++) line(50, 30);
        // R5: short sync truncates the pulse
        tag = "R5";
        for (int i = 0; i < 3; i++) line(10, 40);
        line(2, 20);

        // R3: automatic mode over all flag combinations
        tag = "R3"; sel = 2'b10;
        for (int k = 0; k < 4; k++) begin
            comp = k[0]; video = k[1];
            line(45, 45);
            line(45, 45);
        end
        sel = 2'b11; comp = 1; video = 0;
        line(45, 45);
        idle(10);

        // R4: width and delay corners
        tag = "R4"; sel = 2'b00;
        wid = 8'd0; dly = 8'd0; line(5, 20);
        wid = 8'd1; line(5, 20);
        dly = 8'd7; wid = 8'd3; line(5, 20);
        sel = 2'b01; wid = 8'd1; dly = 8'd0; line(5, 20);
        wid = 8'd30; dly = 8'd2;
        idle(5);

        // R6: lines shorter than the pulse restart the timer
        tag = "R6"; sel = 2'b00;
        for (int i = 0; i < 4; i++) line(3, 8);
        sel = 2'b01;
        for (int i = 0; i < 2; i++) line(40, 2);
        idle(50);

        // R7: vertical blanking with and without separate sync
        tag = "R7"; sel = 2'b00; vd = 1; sep = 0;
        line(10, 50);
        sep = 1; line(10, 50);
        vd = 0; sep = 0; line(10, 50);
        vd = 1; line(5, 10);
        vd = 0; idle(40);

        // Random lines in blocks of fixed timing
        for (int b = 0; b < 5; b++) begin
            dly = 8'($urandom_range(0, 5));
            wid = 8'($urandom_range(0, 40));
            for (int l = 0; l < 60; l++) begin
                sel   = 2'($urandom_range(0, 3));
                comp  = 1'($urandom_range(0, 1));
                video = 1'($urandom_range(0, 1));
                sep   = 1'($urandom_range(0, 1));
                vd    = ($urandom_range(0, 5) == 0);
                if (vd && !sep)     tag = "R7";
                else if (sel[1])    tag = "R3";
                else if (sel == 2'b01) tag = "R2";
                else                tag = "R1";
                line($urandom_range(2, 40), $urandom_range(2, 80));
            end
            vd = 0; tag = "R4";
            idle(60);
        end

        // R9: reset mid-pulse clears output
        tag = "R9"; sel = 2'b00; wid = 8'd30; dly = 8'd0;
        line(4, 6);
        rst_n = 0;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1;
        idle(5);

        finish_run();
    end
endmodule